// File: doc/BRIEF.md
# Logical-to-Physical Bank Mapper

This block widens a 16-bit logical memory address into a physical address by putting a bank number above it. The bank number is chosen from the kind of memory access, from the half of the logical space that the address falls in (its most significant bit), and from an interrupt-mode flag. Most bank numbers come from six software-loaded bank registers, named R32 to R37. In some combinations a fixed bank number is used in their place.

The register bank is loaded through a small write port made of an index, data and a strobe. The mapping itself has no registers in its path, so the physical address follows the inputs within the same cycle. Only the error flag for an undefined access code is registered. Access codes: 0 is case A (instruction fetches, and link-pointer fetches and direct accesses outside the base page). 1 is case B (link-pointer fetches and direct accesses inside the base page). 2 is case C (final targets of indirect accesses, and I/O or extended accesses, including interrupt vector fetches). 3 is case D (DMA). Codes 4 to 7 are undefined.

Top module: `bank_xlate`

## Requirements
- R1: For a defined access code, `phys_addr` equals {bank, `addr`}: the 16 low bits carry `addr` unchanged and the BANK_W high bits carry the selected bank number.
- R2: Address bit 15 picks the mapping: a set bit uses the top-half source and a clear bit uses the bottom-half source.
- R3: A case-C access (code 2) whose address bits 15 to 9 are all ones is mapped exactly as case B. No other case, and no case-C address with any of those bits clear, is changed by this rule.
- R4: With `int_mode` low, the sources (top half / bottom half) are: case A R34/R33, case B R36/R33, case C R32/R35, case D R32/R37.
- R5: With `int_mode` high, the sources (top half / bottom half) are: case A R34/constant 5, case B constant 1/constant 5, case C constant 0/R35, case D R32/R37.
- R6: A write with `wr_en` high and `wr_idx` 0 to 5 loads `wr_data` into R32 to R37 respectively. The new value is used from the next clock edge on. Writes with `wr_idx` 6 or 7 change no register.
- R7: Reset (`rst_n` low) clears all six bank registers to zero and clears `case_err`.
- R8: An undefined access code (4 to 7) forces `phys_addr` to zero in the same cycle. `case_err` is high for the cycle after each clock edge that sampled an undefined code, and low after an edge that sampled a defined code.
- R9: `phys_addr` follows changes of `acc_case`, `addr` and `int_mode` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bank register write strobe |
| wr_idx | input | 3 | Register index, 0 = R32 to 5 = R37 |
| wr_data | input | BANK_W | Value to load into the bank register |
| acc_case | input | 3 | Access code: 0 A, 1 B, 2 C, 3 D, 4 to 7 undefined |
| addr | input | ADDR_W | Logical address |
| int_mode | input | 1 | Interrupt-mode flag |
| phys_addr | output | BANK_W+ADDR_W | Physical address {bank, addr} |
| case_err | output | 1 | Registered flag for an undefined access code |

## Verification
The bench builds the block with BANK_W set to 6 instead of the default 4. This lets the six bank registers hold distinct values of up to 63, all different from the constants 0, 1 and 5, so a wrong register, or a constant taken where a register was due, shows up as a wrong upper field. With a 6-bit field, the bench can also tell a wrong bank from a wrong write (R6) and a cleared result (R8). The address width stays at 16, so the base-page boundary at 0xFE00 and bit 15 are exercised at their actual positions.

// File: rtl/bx_pkg.sv
package bx_pkg;

  localparam int NUM_BANK_REGS = 6;
  localparam int BP_BITS       = 7;

  localparam logic [2:0] ACC_A = 3'd0;
  localparam logic [2:0] ACC_B = 3'd1;
  localparam logic [2:0] ACC_C = 3'd2;
  localparam logic [2:0] ACC_D = 3'd3;

  // register slot numbers: slot k holds R(32+k)
  localparam logic [2:0] SLOT_R32 = 3'd0;
  localparam logic [2:0] SLOT_R33 = 3'd1;
  localparam logic [2:0] SLOT_R34 = 3'd2;
  localparam logic [2:0] SLOT_R35 = 3'd3;
  localparam logic [2:0] SLOT_R36 = 3'd4;
  localparam logic [2:0] SLOT_R37 = 3'd5;

  typedef struct packed {
    logic       use_const;
    logic [2:0] slot;
    logic [2:0] const_val;
  } bank_src_t;

  function automatic bank_src_t reg_src(logic [2:0] slot);
    bank_src_t s;
    s.use_const = 1'b0;
    s.slot      = slot;
    s.const_val = 3'd0;
    return s;
  endfunction

  function automatic bank_src_t const_src(logic [2:0] val);
    bank_src_t s;
    s.use_const = 1'b1;
    s.slot      = 3'd0;
    s.const_val = val;
    return s;
  endfunction

  // Source table; cls must already hold the base-page override.
  function automatic bank_src_t pick_src(logic [2:0] cls, logic top, logic im);
    bank_src_t s;
    case (cls)
      ACC_A:   s = top ? reg_src(SLOT_R34)
                       : (im ? const_src(3'd5) : reg_src(SLOT_R33));
      ACC_B:   s = top ? (im ? const_src(3'd1) : reg_src(SLOT_R36))
                       : (im ? const_src(3'd5) : reg_src(SLOT_R33));
      ACC_C:   s = top ? (im ? const_src(3'd0) : reg_src(SLOT_R32))
                       : reg_src(SLOT_R35);
      default: s = top ? reg_src(SLOT_R32) : reg_src(SLOT_R37);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bx_regfile.sv
module bx_regfile #(
  parameter int BANK_W = 4,
  parameter int NREGS  = bx_pkg::NUM_BANK_REGS,
  localparam int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [BANK_W-1:0]            wr_data,
  output logic [NREGS-1:0][BANK_W-1:0] bank_q
);

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   bank_q[g] <= '0;
      else if (hit) bank_q[g] <= wr_data;
    end
  end

endmodule

// File: rtl/bx_select.sv
module bx_select #(
  parameter int ADDR_W = 16
) (
  input  logic [2:0]         acc_case,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               int_mode,
  output logic               bad_case,
  output logic               top_half,
  output logic               bp_override,
  output logic [2:0]         eff_cls,
  output bx_pkg::bank_src_t  src
);
  import bx_pkg::*;

  localparam int BP_LO = ADDR_W - BP_BITS;

  logic in_bp_top;

  assign bad_case    = acc_case[2];
  assign top_half    = addr[ADDR_W-1];
  assign in_bp_top   = &addr[ADDR_W-1:BP_LO];
  assign bp_override = (acc_case == ACC_C) && in_bp_top;
  assign eff_cls     = bp_override ? ACC_B : acc_case;

  always_comb begin
    src = pick_src(eff_cls, top_half, int_mode);
  end

endmodule

// File: rtl/bx_bankmux.sv
module bx_bankmux #(
  parameter int BANK_W = 4,
  parameter int NREGS  = bx_pkg::NUM_BANK_REGS
) (
  input  logic [NREGS-1:0][BANK_W-1:0] bank_q,
  input  bx_pkg::bank_src_t            src,
  output logic [BANK_W-1:0]            bank_sel
);

  logic [BANK_W-1:0] reg_val;

  always_comb begin
    reg_val = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (src.slot == 3'(i)) reg_val = bank_q[i];
    end
  end

  assign bank_sel = src.use_const ? BANK_W'(src.const_val) : reg_val;

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4,
  localparam int PHYS_W = BANK_W + ADDR_W,
  localparam int NREGS  = bx_pkg::NUM_BANK_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [2:0]        acc_case,
  input  logic [ADDR_W-1:0] addr,
  input  logic              int_mode,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              case_err
);
  import bx_pkg::*;

  logic [NREGS-1:0][BANK_W-1:0] bank_q;
  logic                         bad_case;
  logic                         top_half;
  logic                         bp_override;
  logic [2:0]                   eff_cls;
  bank_src_t                    src;
  logic [BANK_W-1:0]            bank_sel;

  bx_regfile #(.BANK_W(BANK_W), .NREGS(NREGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .bank_q  (bank_q)
  );

  bx_select #(.ADDR_W(ADDR_W)) u_sel (
    .acc_case    (acc_case),
    .addr        (addr),
    .int_mode    (int_mode),
    .bad_case    (bad_case),
    .top_half    (top_half),
    .bp_override (bp_override),
    .eff_cls     (eff_cls),
    .src         (src)
  );

  bx_bankmux #(.BANK_W(BANK_W), .NREGS(NREGS)) u_mux (
    .bank_q   (bank_q),
    .src      (src),
    .bank_sel (bank_sel)
  );

  assign phys_addr = bad_case ? '0 : {bank_sel, addr};

  always_ff @(posedge clk) begin
    if (!rst_n) case_err <= 1'b0;
    else        case_err <= bad_case;
  end

endmodule

// File: rtl/bx_chk.sv
module bx_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4,
  parameter int NREGS  = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [2:0]                   wr_idx,
  input logic [BANK_W-1:0]            wr_data,
  input logic [2:0]                   acc_case,
  input logic [ADDR_W-1:0]            addr,
  input logic                         int_mode,
  input logic [BANK_W+ADDR_W-1:0]     phys_addr,
  input logic                         case_err,
  input logic                         bad_case,
  input logic                         top_half,
  input logic                         bp_override,
  input logic [NREGS-1:0][BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_out;
  assign bank_out = phys_addr[BANK_W+ADDR_W-1:ADDR_W];

  p_low_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_case |-> phys_addr[ADDR_W-1:0] == addr);

  p_bp_as_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_override && !int_mode) |-> bank_out == bank_q[4]);

  p_bp_im_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_override && int_mode) |-> bank_out == BANK_W'(1));

  p_vec_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_case == 3'd2 && int_mode && top_half && !bp_override) |-> bank_out == '0);

  p_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_case == 3'd3) |-> bank_out == (top_half ? bank_q[0] : bank_q[5]));

  p_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 3'(NREGS)) |=> bank_q[$past(wr_idx)] == $past(wr_data));

  p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q));

  p_bad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_case |-> phys_addr == '0);

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_case |=> case_err);

  p_err_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_case |=> !case_err);

endmodule

bind bank_xlate bx_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .NREGS(NREGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .acc_case    (acc_case),
  .addr        (addr),
  .int_mode    (int_mode),
  .phys_addr   (phys_addr),
  .case_err    (case_err),
  .bad_case    (bad_case),
  .top_half    (top_half),
  .bp_override (bp_override),
  .bank_q      (bank_q)
);

// File: tb/bank_xlate_tb_top.sv
module bank_xlate_tb_top;
  localparam int AW = 16;
  localparam int BW = 6;
  localparam int PW = AW + BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [BW-1:0] wr_data = '0;
  logic [2:0]    acc_case = '0;
  logic [AW-1:0] addr = '0;
  logic          int_mode = 1'b0;
  logic [PW-1:0] phys_addr;
  logic          case_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // shadow of R32..R37, indexed by register number minus 32
  int shadow [6];

  always #5 clk = ~clk;

  bank_xlate #(.ADDR_W(AW), .BANK_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .acc_case(acc_case), .addr(addr), .int_mode(int_mode),
    .phys_addr(phys_addr), .case_err(case_err)
  );

  // Source tables: a value >= 32 names register Rn, a smaller value is a constant.
  function automatic int exp_bank(int cs, int a, bit im);
    int top_t0 [4] = '{34, 36, 32, 32};
    int bot_t0 [4] = '{33, 33, 35, 37};
    int top_t1 [4] = '{34, 1, 0, 32};
    int bot_t1 [4] = '{5, 5, 35, 37};
    int c = cs;
    int src;
    bit hi = a[15];
    if (c == 2 && a >= 'hFE00) c = 1;
    if (im) src = hi ? top_t1[c] : bot_t1[c];
    else    src = hi ? top_t0[c] : bot_t0[c];
    return (src >= 32) ? shadow[src-32] : src;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic probe(string req, int cs, int a, bit im);
    @(negedge clk);
    acc_case = 3'(cs); addr = 16'(a); int_mode = im;
    #1;
    check(req, phys_addr, (longint'(exp_bank(cs, a, im)) << AW) | a);
  endtask

  task automatic write_reg(int idx, int val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = BW'(val);
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 6) shadow[idx] = val;
  endtask

  task automatic t_reset;
    foreach (shadow[i]) shadow[i] = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 case_err in reset", case_err, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < 4; c++) probe("R7 zero banks", c, 'h8000 + 'h123 * c, 1'b0);
  endtask

  task automatic t_load;
    int vals [6] = '{11, 22, 33, 44, 55, 60};
    for (int i = 0; i < 6; i++) write_reg(i, vals[i]);
    for (int c = 0; c < 4; c++) begin
      probe("R6 load visible top", c, 'h9000, 1'b0);
      probe("R6 load visible bottom", c, 'h0100, 1'b0);
    end
  endtask

  task automatic t_map_clear;
    int addrs [4] = '{'h0000, 'h7FFF, 'h8000, 'hC3A5};
    for (int c = 0; c < 4; c++)
      foreach (addrs[k]) probe("R4 R2 R1 im clear", c, addrs[k], 1'b0);
  endtask

  task automatic t_map_set;
    int addrs [4] = '{'h0001, 'h4ABC, 'h8001, 'hF000};
    for (int c = 0; c < 4; c++)
      foreach (addrs[k]) probe("R5 R2 im set", c, addrs[k], 1'b1);
  endtask

  task automatic t_base_page;
    for (int m = 0; m < 2; m++) begin
      probe("R3 C at FE00", 2, 'hFE00, m[0]);
      probe("R3 C at FFFF", 2, 'hFFFF, m[0]);
      probe("R3 C at FDFF", 2, 'hFDFF, m[0]);
      probe("R3 A at FE00", 0, 'hFE00, m[0]);
      probe("R3 D at FF80", 3, 'hFF80, m[0]);
    end
  endtask

  task automatic t_ignored_idx;
    write_reg(6, 63);
    write_reg(7, 62);
    probe("R6 idx6/7 keep R32", 2, 'h8000, 1'b0);
    probe("R6 idx6/7 keep R33", 0, 'h0000, 1'b0);
    probe("R6 idx6/7 keep R34", 0, 'h8000, 1'b0);
    probe("R6 idx6/7 keep R35", 2, 'h0000, 1'b0);
    probe("R6 idx6/7 keep R36", 1, 'h8000, 1'b0);
    probe("R6 idx6/7 keep R37", 3, 'h0000, 1'b0);
    write_reg(3, 7);
    probe("R6 rewrite R35", 2, 'h1234, 1'b1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    acc_case = 3'd3; addr = 16'h0042; int_mode = 1'b0;
    #1 check("R9 same cycle first", phys_addr, (longint'(shadow[5]) << AW) | 'h42);
    #2 addr = 16'h8042;
    #1 check("R9 same cycle addr", phys_addr, (longint'(shadow[0]) << AW) | 'h8042);
    acc_case = 3'd1; int_mode = 1'b1;
    #1 check("R9 same cycle mode", phys_addr, (longint'(1) << AW) | 'h8042);
  endtask

  task automatic t_bad_code;
    for (int c = 4; c < 8; c++) begin
      @(negedge clk);
      acc_case = 3'(c); addr = 16'hABCD; int_mode = c[0];
      #1 check("R8 bad code zero", phys_addr, 0);
      @(posedge clk); #1;
      check("R8 err raised", case_err, 1);
    end
    @(negedge clk);
    acc_case = 3'd0; addr = 16'h0010;
    #1 check("R8 err holds until edge", case_err, 1);
    @(posedge clk); #1;
    check("R8 err cleared", case_err, 0);
  endtask

  initial begin
    t_reset;
    t_load;
    t_map_clear;
    t_map_set;
    t_base_page;
    t_ignored_idx;
    t_same_cycle;
    t_bad_code;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule